// File: doc/BRIEF.md
# Share-Masked Boolean Gate Unit

This unit evaluates one Boolean operation per cycle on secrets that never appear in plain form. Each operand bit arrives as `SHARES` shares, and the XOR of all shares is the secret bit. With `SHARES = 2t+1`, an observer who can watch up to t internal wires in a given cycle learns nothing about either secret. The result also leaves the unit as shares, so a chain of these units can evaluate a whole circuit without ever recombining a secret.

Four operations are selected by a 2-bit opcode: negation, XOR, AND, and a plain copy of the first operand. Negation flips one share only. XOR works share by share and needs no randomness. AND builds every cross product of shares and masks each pair of indices with its own fresh random bit taken from an input bus. The caller must split each secret into shares with a random split, because a fixed split would let a single probe reveal the secret.

A valid input is captured on the next rising clock edge. The result and its valid flag appear one cycle later. When no valid input arrives, the output shares keep their last value.

Top module: `masked_gate_unit`

## Requirements
- R1: While `rst_n` is low, and after reset is released but before the first valid input, `out_valid` is 0 and every bit of `y_sh` is 0.
- R2: `out_valid` equals `in_valid` one clock edge earlier. A result appears exactly one cycle after its input.
- R3: Opcode 2'b00 (negate a): `y_sh[0]` is the inverse of `a_sh[0]`, and each other share `y_sh[k]` equals `a_sh[k]`.
- R4: Opcode 2'b01 (XOR): `y_sh[k] = a_sh[k] ^ b_sh[k]` for every k, whatever value `rnd` holds.
- R5: Opcode 2'b10 (AND): the XOR of all output shares equals (XOR of `a_sh`) AND (XOR of `b_sh`), for any value of `rnd`.
- R6: For the AND, share i is `a_i&b_i`, XORed with the masking terms z(i,j) for every j other than i. For i<j, z(i,j) is `rnd[p]`, and z(j,i) is `(rnd[p] ^ a_i&b_j) ^ a_j&b_i`. The pair index is p = i*SHARES - i*(i+1)/2 + (j-i-1). `rnd` is SHARES*(SHARES-1)/2 bits wide.
- R7: Opcode 2'b11 (copy): `y_sh` equals `a_sh`.
- R8: When `in_valid` is low, `y_sh` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operands and opcode are valid |
| op | input | 2 | Operation: 00 negate, 01 XOR, 10 AND, 11 copy |
| a_sh | input | SHARES | Shares of operand a |
| b_sh | input | SHARES | Shares of operand b |
| rnd | input | SHARES*(SHARES-1)/2 | Fresh random mask bits, one per share pair |
| out_valid | output | 1 | `y_sh` holds a new result |
| y_sh | output | SHARES | Shares of the result |

## Verification
The bench builds the unit with `SHARES = 5`, which gives t = 2 and a 10-bit mask bus. This width exercises the pair-index formula well beyond the smallest case: rows with several masks lie below the diagonal and several above it. A wrong bracket order or a swapped pair therefore changes exact share values, and the bench compares those values against its own model of R6. Random secrets are split with random shares and paired with random masks. Directed cases add all-zero and all-one operands, all-zero and all-one masks, and idle gaps that test the hold behaviour.

// File: rtl/masked_gate_unit.sv
module masked_gate_unit #(
  parameter int SHARES = 3,
  localparam int NRND = SHARES * (SHARES - 1) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [SHARES-1:0] a_sh,
  input  logic [SHARES-1:0] b_sh,
  input  logic [NRND-1:0]   rnd,
  output logic              out_valid,
  output logic [SHARES-1:0] y_sh
);
  localparam logic [1:0] OP_NOT = 2'b00;
  localparam logic [1:0] OP_XOR = 2'b01;
  localparam logic [1:0] OP_AND = 2'b10;

  logic [SHARES*SHARES-1:0] zz;
  logic [SHARES-1:0] and_sh, not_sh, nxt;

  for (genvar i = 0; i < SHARES; i++) begin : g_row
    for (genvar j = 0; j < SHARES; j++) begin : g_col
      if (j > i) begin : g_pair
        localparam int P = i * SHARES - (i * (i + 1)) / 2 + (j - i - 1);
        assign zz[i*SHARES+j] = rnd[P];
        assign zz[j*SHARES+i] = (rnd[P] ^ (a_sh[i] & b_sh[j])) ^ (a_sh[j] & b_sh[i]);
      end else if (j == i) begin : g_diag
        assign zz[i*SHARES+i] = 1'b0;
      end
    end
    assign and_sh[i] = (a_sh[i] & b_sh[i]) ^ (^zz[i*SHARES +: SHARES]);
  end

  assign not_sh = {a_sh[SHARES-1:1], ~a_sh[0]};

  always_comb begin
    case (op)
      OP_NOT:  nxt = not_sh;
      OP_XOR:  nxt = a_sh ^ b_sh;
      OP_AND:  nxt = and_sh;
      default: nxt = a_sh;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      y_sh      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) y_sh <= nxt;
    end
  end
endmodule

// File: rtl/masked_gate_unit_chk.sv
module masked_gate_unit_chk #(
  parameter int SHARES = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        op,
  input logic [SHARES-1:0] a_sh,
  input logic [SHARES-1:0] b_sh,
  input logic              out_valid,
  input logic [SHARES-1:0] y_sh
);
  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r3_not_one_share: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b00) |=>
      (y_sh[SHARES-1:1] == $past(a_sh[SHARES-1:1])) && (y_sh[0] != $past(a_sh[0])));
  a_r4_xor_sharewise: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b01) |=> y_sh == $past(a_sh ^ b_sh));
  a_r5_and_recombine: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b10) |=> (^y_sh) == ($past(^a_sh) & $past(^b_sh)));
  a_r7_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b11) |=> y_sh == $past(a_sh));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(y_sh));
endmodule

bind masked_gate_unit masked_gate_unit_chk #(.SHARES(SHARES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
  .a_sh(a_sh), .b_sh(b_sh), .out_valid(out_valid), .y_sh(y_sh)
);

// File: tb/masked_gate_unit_test.sv
`timescale 1ns/1ps
module masked_gate_unit_test;
  localparam int M  = 5;
  localparam int NR = M * (M - 1) / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    op = 2'b00;
  logic [M-1:0]  a_sh = '0, b_sh = '0;
  logic [NR-1:0] rnd = '0;
  logic          out_valid;
  logic [M-1:0]  y_sh;

  int checks = 0, failures = 0;
  logic [M-1:0] last_y = '0;

  always #5 clk = ~clk;

  masked_gate_unit #(.SHARES(M)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .a_sh(a_sh), .b_sh(b_sh), .rnd(rnd), .out_valid(out_valid), .y_sh(y_sh)
  );

  function automatic int pidx(int i, int j);
    return i * M - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction

  function automatic logic [M-1:0] split(logic x);
    logic [M-1:0] s;
    s = M'($urandom);
    s[M-1] = x ^ (^s[M-2:0]);
    return s;
  endfunction

  function automatic logic [M-1:0] model(logic [1:0] o, logic [M-1:0] a,
                                        logic [M-1:0] b, logic [NR-1:0] r);
    logic [M-1:0] c;
    case (o)
      2'b00: begin c = a; c[0] = ~a[0]; end
      2'b01: c = a ^ b;
      2'b11: c = a;
      default: begin
        for (int i = 0; i < M; i++) begin
          c[i] = a[i] & b[i];
          for (int j = 0; j < M; j++) begin
            if (j > i) c[i] ^= r[pidx(i, j)];
            else if (j < i) c[i] ^= (r[pidx(j, i)] ^ (a[j] & b[i])) ^ (a[i] & b[j]);
          end
        end
      end
    endcase
    return c;
  endfunction

  task automatic check(string req, logic [M-1:0] act, logic [M-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [1:0] o, logic [M-1:0] a,
                      logic [M-1:0] b, logic [NR-1:0] r);
    logic [M-1:0] exp;
    in_valid = v; op = o; a_sh = a; b_sh = b; rnd = r;
    exp = v ? model(o, a, b, r) : last_y;
    @(negedge clk);
    check("R2", M'(out_valid), M'(v));
    if (!v) check("R8", y_sh, exp);
    else case (o)
      2'b00: check("R3", y_sh, exp);
      2'b01: check("R4", y_sh, exp);
      2'b10: begin
        check("R6", y_sh, exp);
        check("R5", M'(^y_sh), M'((^a) & (^b)));
      end
      default: check("R7", y_sh, exp);
    endcase
    last_y = exp;
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", M'(out_valid), '0);
    check("R1", y_sh, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", y_sh, '0);
    // directed corners
    step(1'b1, 2'b10, '0, '0, '0);
    step(1'b1, 2'b10, '1, '1, '0);
    step(1'b1, 2'b10, '1, '1, '1);
    step(1'b1, 2'b10, 5'b00001, 5'b10000, 10'b1010011001);
    step(1'b0, 2'b00, '1, '1, '1);
    step(1'b1, 2'b01, '1, 5'b01010, '1);
    step(1'b1, 2'b00, '0, '1, '1);
    step(1'b1, 2'b11, 5'b10110, '1, '1);
    step(1'b0, 2'b01, '0, '1, '0);
    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic x, y;
      x = 1'($urandom);
      y = 1'($urandom);
      step(($urandom % 5) != 0, 2'($urandom), split(x), split(y), NR'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule